// File: doc/BRIEF.md
# Burst-of-Two Separate-Port Memory Core

This block is a synchronous memory with an independent write data input and read data output. It is clocked at the beat rate, so each clock cycle carries one beat of the external data bus. The array word is two beats wide. The address therefore selects a double-width word and has one bit fewer than log2 of the beat-level depth. With the default depth of 32 beats, the address is 4 bits wide and selects one of 16 words.

A write is issued with its address and the first data beat in one cycle, and the second beat follows in the next cycle. Both beats are stored in the array together. A read fetches one whole word and returns it as two consecutive output beats, after a latency of two or three cycles chosen by a select input. A read and a write may be issued in the same cycle. The read and write paths are coherent: a read returns every write issued in the same cycle or earlier, and no write issued later.

Top module: `bsram_core`

## Requirements
- R1: A write stores its first beat (issued with `wr_en`) in the low half of the word and its second beat (on `wr_data` in the next cycle) in the high half. A later read of that word returns the low half on its first output beat and the high half on its second.
- R2: With `lat_sel` = 0, a read issued in cycle T presents its first beat in cycle T+2 and its second beat in cycle T+3.
- R3: With `lat_sel` = 1, a read issued in cycle T presents its first beat in cycle T+3 and its second beat in cycle T+4. `lat_sel` changes only while no read is outstanding.
- R4: `rd_valid` is high for exactly the two beats of each read and low otherwise. Read commands are issued at least two cycles apart, and so are write commands.
- R5: A read and a write may be issued in the same cycle. If they name the same address, the read returns the word being written.
- R6: A read issued one cycle after a write to the same address, while that write's second beat is on the bus, returns the new word.
- R7: A write to the same address issued one cycle after a read does not affect that read, which returns the old word.
- R8: A synchronous active-low reset drops reads in flight. `rd_valid` is low from the cycle after reset is sampled and stays low until a new read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_sel | input | 1 | Read latency select: 0 gives two cycles, 1 gives three cycles |
| wr_en | input | 1 | Write command; the first beat is on `wr_data` in the same cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | BEAT_W | Write data beat |
| rd_en | input | 1 | Read command |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | BEAT_W | Read data beat |
| rd_valid | output | 1 | High while `rd_data` carries a read beat |

## Verification
The assertions take for granted that commands on each port are spaced at least two cycles apart, so that a write's second beat never collides with a new write and output bursts never overlap. They also assume that `lat_sel` stays fixed while a read is in the pipeline.

The stimulus keeps within these limits. Each table entry occupies a two-cycle slot. The latency is changed only after the output has drained. The directed one-cycle-offset tests place exactly one command of each kind inside a two-cycle window.

// File: rtl/bsram_pkg.sv
// Shared definitions for the burst-of-two memory core.
// Assumes: nothing beyond the types declared here.
package bsram_pkg;
    typedef enum logic {
        LAT_TWO   = 1'b0,
        LAT_THREE = 1'b1
    } lat_e;
endpackage

// File: rtl/bsram_wr_gather.sv
// Write gatherer: holds the first beat of a write and its address,
// then presents the complete double-width word for commit in the cycle
// the second beat is on the bus.
// Assumes write commands are at least two cycles apart.
module bsram_wr_gather #(
    parameter int BEAT_W = 18,
    parameter int ADDR_W = 4,
    localparam int WORD_W = 2 * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BEAT_W-1:0] wr_data,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [WORD_W-1:0] commit_word
);
    logic              second_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BEAT_W-1:0] low_q;

    // Capture the address and first beat when a write is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
            addr_q   <= '0;
            low_q    <= '0;
        end else begin
            second_q <= wr_en;
            if (wr_en) begin
                addr_q <= wr_addr;
                low_q  <= wr_data;
            end
        end
    end

    // The second beat on the bus forms the high half of the committed word.
    always_comb begin
        commit      = second_q;
        commit_addr = addr_q;
        commit_word = {wr_data, low_q};
    end

    assert_wr_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        second_q |-> !wr_en);

    assert_commit_word_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !second_q) |=> (commit && commit_word[BEAT_W-1:0] == $past(wr_data)));
endmodule

// File: rtl/bsram_array.sv
// Word array: one synchronous write port and one combinational read port.
// Assumes the depth is a power of two set by the address width.
module bsram_array #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store a committed word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Look up the word at the read address.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/bsram_rd_serial.sv
// Output serializer: holds one fetched word and drives its low half and
// then its high half on two consecutive cycles, with a valid flag.
// Assumes a new load arrives no sooner than the second beat of the last one.
module bsram_rd_serial #(
    parameter int BEAT_W = 18,
    localparam int WORD_W = 2 * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [BEAT_W-1:0] beat,
    output logic              valid
);
    logic [WORD_W-1:0] word_q;
    logic              active_q;
    logic              high_q;

    // Step through the two beats of each loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            active_q <= 1'b0;
            high_q   <= 1'b0;
        end else if (load) begin
            word_q   <= word;
            active_q <= 1'b1;
            high_q   <= 1'b0;
        end else if (active_q && !high_q) begin
            high_q <= 1'b1;
        end else begin
            active_q <= 1'b0;
            high_q   <= 1'b0;
        end
    end

    // Select the half of the held word for the current beat.
    always_comb begin
        valid = active_q;
        beat  = high_q ? word_q[WORD_W-1:BEAT_W] : word_q[BEAT_W-1:0];
    end

    assert_burst_second_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !high_q) |=> valid);

    assert_burst_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && high_q && !load) |=> !valid);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !high_q) |-> !load);
endmodule

// File: rtl/bsram_core.sv
// Burst-of-two separate-port memory core. The array is read in the cycle
// after a read is issued, and a write whose second beat is on the bus in
// that cycle is forwarded. The fetched word then passes through zero or one
// extra stage, chosen by lat_sel, before the serializer.
// Assumes command spacing of two cycles per port and a stable lat_sel
// while a read is outstanding.
module bsram_core
    import bsram_pkg::*;
#(
    parameter int BEAT_W     = 18,
    parameter int BEAT_DEPTH = 32,
    localparam int ADDR_W    = $clog2(BEAT_DEPTH) - 1,
    localparam int WORD_W    = 2 * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BEAT_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BEAT_W-1:0] rd_data,
    output logic              rd_valid
);
    lat_e              lat;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] array_word;
    logic [WORD_W-1:0] fetched;
    logic              ra_v;
    logic [ADDR_W-1:0] ra_addr;
    logic              rb_v;
    logic [WORD_W-1:0] rb_word;
    logic              ser_load;
    logic [WORD_W-1:0] ser_word;

    assign lat = lat_e'(lat_sel);

    bsram_wr_gather #(.BEAT_W(BEAT_W), .ADDR_W(ADDR_W)) u_gather (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .commit_addr(commit_addr),
        .commit_word(commit_word)
    );

    bsram_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(commit), .waddr(commit_addr), .wdata(commit_word),
        .raddr(ra_addr), .rdata(array_word)
    );

    // Forward a write completing in the fetch cycle to a read of the same word.
    always_comb begin
        fetched = (commit && commit_addr == ra_addr) ? commit_word : array_word;
    end

    // Register the read command, then optionally delay the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_v    <= 1'b0;
            ra_addr <= '0;
            rb_v    <= 1'b0;
            rb_word <= '0;
        end else begin
            ra_v <= rd_en;
            if (rd_en) ra_addr <= rd_addr;
            rb_v <= ra_v && (lat == LAT_THREE);
            if (ra_v) rb_word <= fetched;
        end
    end

    // Feed the serializer from the fetch cycle or from the extra stage.
    always_comb begin
        if (lat == LAT_TWO) begin
            ser_load = ra_v;
            ser_word = fetched;
        end else begin
            ser_load = rb_v;
            ser_word = rb_word;
        end
    end

    bsram_rd_serial #(.BEAT_W(BEAT_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .word(ser_word),
        .beat(rd_data), .valid(rd_valid)
    );

    assert_rd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ra_v |-> !rd_en);

    assert_lat_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_v || rb_v) |-> $stable(lat_sel));

    assert_latency_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en, 2) && !$past(lat_sel, 2) && $past(rst_n, 1) && $past(rst_n, 2))
        |-> rd_valid);

    assert_latency_three_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en, 3) && $past(lat_sel, 3) && $past(rst_n, 1) && $past(rst_n, 2)
         && $past(rst_n, 3)) |-> rd_valid);

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> !rd_valid);
endmodule

// File: tb/tb_bsram_core.sv
// Bench for bsram_core: a table of two-cycle command slots, walked once
// per latency setting against a reference array, then directed tests.
module tb_bsram_core;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 18;
    localparam int AW = 4;
    localparam int VW = 1 + AW + BW + BW + 1 + AW;
    localparam int NV = 12;

    // Fields per entry: write enable, write address, beat 0, beat 1, read enable, read address.
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 4'd0,  18'h00011, 18'h00022, 1'b0, 4'd0},
        {1'b1, 4'd15, 18'h00033, 18'h00044, 1'b1, 4'd0},
        {1'b1, 4'd3,  18'h00055, 18'h00066, 1'b1, 4'd3},
        {1'b0, 4'd0,  18'h00000, 18'h00000, 1'b1, 4'd15},
        {1'b1, 4'd3,  18'h00077, 18'h00088, 1'b1, 4'd15},
        {1'b0, 4'd0,  18'h00000, 18'h00000, 1'b1, 4'd3},
        {1'b1, 4'd7,  18'h3a1a1, 18'h0b2b2, 1'b1, 4'd7},
        {1'b1, 4'd7,  18'h1c3c3, 18'h2d4d4, 1'b1, 4'd7},
        {1'b0, 4'd0,  18'h00000, 18'h00000, 1'b1, 4'd7},
        {1'b0, 4'd0,  18'h00000, 18'h00000, 1'b1, 4'd0},
        {1'b1, 4'd0,  18'h0e5e5, 18'h0f6f6, 1'b1, 4'd15},
        {1'b0, 4'd0,  18'h00000, 18'h00000, 1'b1, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lat_sel = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [BW-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [BW-1:0] rd_data;
    logic rd_valid;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic monitor_on = 1'b0;
    logic [2*BW-1:0] ref_mem [1 << AW];
    logic [BW-1:0] exp_beat [$];
    int exp_cyc [$];
    string exp_tag [$];

    bsram_core #(.BEAT_W(BW), .BEAT_DEPTH(32)) dut (
        .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Compare every cycle: valid with the right beat when one is due, low otherwise.
    always @(negedge clk) begin
        if (monitor_on) begin
            checks++;
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                if (!rd_valid || rd_data !== exp_beat[0]) begin
                    fails++;
                    $display("FAIL %s: cycle %0d valid=%0b data=%h expected valid=1 data=%h",
                             exp_tag[0], cyc, rd_valid, rd_data, exp_beat[0]);
                end
                void'(exp_cyc.pop_front());
                void'(exp_beat.pop_front());
                void'(exp_tag.pop_front());
            end else if (rd_valid) begin
                fails++;
                $display("FAIL R4: cycle %0d valid=1 data=%h expected valid=0", cyc, rd_data);
            end
        end
    end

    // Record the write in the reference; later reads see it.
    task automatic ref_write(input logic [AW-1:0] a, input logic [BW-1:0] d0,
                             input logic [BW-1:0] d1);
        ref_mem[a] = {d1, d0};
    endtask

    // Queue the two expected beats of a read issued in the current cycle.
    task automatic expect_read(input logic [AW-1:0] a, input string tag);
        int lat;
        lat = lat_sel ? 3 : 2;
        exp_cyc.push_back(cyc + lat);
        exp_beat.push_back(ref_mem[a][BW-1:0]);
        exp_tag.push_back(tag);
        exp_cyc.push_back(cyc + lat + 1);
        exp_beat.push_back(ref_mem[a][2*BW-1:BW]);
        exp_tag.push_back(tag);
    endtask

    // One two-cycle slot: optional write and read issued together.
    task automatic slot(input logic we, input logic [AW-1:0] wa, input logic [BW-1:0] d0,
                        input logic [BW-1:0] d1, input logic re, input logic [AW-1:0] ra);
        wr_en = we; wr_addr = wa; wr_data = d0;
        rd_en = re; rd_addr = ra;
        if (we) ref_write(wa, d0, d1);
        if (re) expect_read(ra, lat_sel ? "R3/R5" : "R2/R5");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_data = d1;
        @(negedge clk);
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R8: reset state, with a read requested while reset is held.
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        monitor_on = 1'b1;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1, R2, R3, R5: table walked once per latency setting.
        for (int pass = 0; pass < 2; pass++) begin
            lat_sel = pass[0];
            for (int i = 0; i < NV; i++) begin
                logic [VW-1:0] v;
                logic [BW-1:0] flip;
                v = VEC[i];
                flip = pass[0] ? 18'h20000 : 18'h0;
                slot(v[VW-1], v[VW-2 -: AW], v[VW-2-AW -: BW] ^ flip,
                     v[VW-2-AW-BW -: BW] ^ flip, v[AW], v[AW-1:0]);
            end
            idle(6);
        end

        // R6: read one cycle after a write to the same word, for each latency.
        for (int l = 0; l < 2; l++) begin
            lat_sel = l[0];
            wr_en = 1'b1; wr_addr = 4'd9; wr_data = 18'h12345 + l;
            ref_write(4'd9, 18'h12345 + l, 18'h2abcd - l);
            @(negedge clk);
            wr_en = 1'b0; wr_data = 18'h2abcd - l;
            rd_en = 1'b1; rd_addr = 4'd9;
            expect_read(4'd9, "R6");
            @(negedge clk);
            rd_en = 1'b0; wr_data = '0;
            idle(6);
        end

        // R7: write issued one cycle after a read of the same word is not seen.
        for (int l = 0; l < 2; l++) begin
            lat_sel = l[0];
            rd_en = 1'b1; rd_addr = 4'd9;
            expect_read(4'd9, "R7");
            @(negedge clk);
            rd_en = 1'b0;
            wr_en = 1'b1; wr_addr = 4'd9; wr_data = 18'h01010 + l;
            ref_write(4'd9, 18'h01010 + l, 18'h30303 + l);
            @(negedge clk);
            wr_en = 1'b0; wr_data = 18'h30303 + l;
            @(negedge clk);
            wr_data = '0;
            rd_en = 1'b1; rd_addr = 4'd9;
            expect_read(4'd9, "R7/R1");
            @(negedge clk);
            rd_en = 1'b0;
            idle(6);
        end

        // R8: a read in flight is dropped by reset; no beat may follow.
        lat_sel = 1'b1;
        rd_en = 1'b1; rd_addr = 4'd3;
        @(negedge clk);
        rd_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(6);

        // R1: the array keeps its contents through reset.
        lat_sel = 1'b0;
        slot(1'b0, 4'd0, '0, '0, 1'b1, 4'd7);
        idle(6);

        if (exp_cyc.size() != 0) begin
            fails++;
            $display("FAIL R4: %0d beats never seen, expected 0", exp_cyc.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule